// File: doc/BRIEF.md
# Banked Register Mode Switcher

This block holds per-mode shadow copies of two high general registers (r29, r30) and of the saved-status word. A switch strobe carries a requested mode code and the values the live registers hold at that moment. On a legal change of mode, the block writes those live values into the bank of the mode being left. It then presents the contents of the entering mode's bank on its restored-value outputs. A register file around it loads those outputs back into its live registers.

The block keeps the current mode itself, starting in user mode after reset. Mode codes are 5 bits wide and are decoded through a parameter table. Six known codes map onto five banks, because user and system-user modes share bank 0. A request for any other code raises a one-cycle illegal-mode flag and changes nothing. A request for the mode already in force does no save and no restore.

Top module: `mode_bank_swap`

## Requirements
- R1: While reset is low, and in the first cycle after it, the restored outputs are zero, the current mode is user (5'h10), and the done and illegal-mode outputs are low.
- R2: The known mode codes are user 5'h10, system-user 5'h1F, privileged 5'h13, trap 5'h17, extension 5'h1B and interrupt 5'h12. User and system-user use bank 0. Privileged, trap, extension and interrupt use banks 1, 2, 3 and 4.
- R3: A strobe that requests a known mode different from the current one is handled in a single clock edge. The live inputs are stored into the bank of the old mode. The restored outputs show the new mode's bank, and the current mode becomes the requested code, from the cycle after the strobe. Without a strobe, outputs and mode hold.
- R4: done is high for exactly the cycle after each edge that performed a switch, and is low at all other times.
- R5: A strobe requesting the current mode causes no save and no restore. Outputs and mode stay unchanged, and done stays low.
- R6: A strobe with a code outside the six known codes drives illegal_mode high for the following cycle only. Mode, outputs and all banks are left unchanged, and done stays low.
- R7: The save happens before the load. A switch between two modes that share a bank therefore restores the live values presented with that same strobe.
- R8: A bank's contents change only when its own mode is left. Switches among other banks do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Mode switch strobe, one cycle per request |
| req_mode | input | 5 | Requested mode code |
| live_r29 | input | DATA_W | Current live value of r29 |
| live_r30 | input | DATA_W | Current live value of r30 |
| live_sts | input | DATA_W | Current live saved-status value |
| out_r29 | output | DATA_W | Restored r29 for the current mode |
| out_r30 | output | DATA_W | Restored r30 for the current mode |
| out_sts | output | DATA_W | Restored saved-status for the current mode |
| cur_mode | output | 5 | Mode code currently in force |
| done | output | 1 | Switch completed at the previous edge |
| illegal_mode | output | 1 | Unknown mode code was requested at the previous edge |

## Verification
Every result of this block is due one edge after the cycle that carries the strobe. This covers the restored values, the new mode, the done pulse and the illegal flag. The driver queues one expected item per driven cycle, including idle cycles. The monitor pops that item shortly after the next rising edge, so each comparison falls in the cycle where the registered outputs first show the effect. Bank contents are checked only through later switches that bring them back out. This is how separate banks, shared banks and rejected codes are each shown to leave stored values intact.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   localparam int MBS_MODE_W = 5;
   typedef logic [MBS_MODE_W-1:0] mbs_mode_t;

   localparam mbs_mode_t MBS_USER   = 5'h10;
   localparam mbs_mode_t MBS_SYSUSR = 5'h1F;
   localparam mbs_mode_t MBS_PRIV   = 5'h13;
   localparam mbs_mode_t MBS_TRAP   = 5'h17;
   localparam mbs_mode_t MBS_EXT    = 5'h1B;
   localparam mbs_mode_t MBS_IRQ    = 5'h12;

   localparam int MBS_NUM_CODES = 6;
   localparam int MBS_NUM_BANKS = 5;
endpackage

// File: rtl/mbs_mode_decode.sv
module mbs_mode_decode
   import mbs_pkg::*;
#(
   parameter int        MODE_W    = MBS_MODE_W,
   parameter int        NUM_BANKS = MBS_NUM_BANKS,
   parameter mbs_mode_t C_USER    = MBS_USER,
   parameter mbs_mode_t C_SYSUSR  = MBS_SYSUSR,
   parameter mbs_mode_t C_PRIV    = MBS_PRIV,
   parameter mbs_mode_t C_TRAP    = MBS_TRAP,
   parameter mbs_mode_t C_EXT     = MBS_EXT,
   parameter mbs_mode_t C_IRQ     = MBS_IRQ,
   localparam int       BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [MODE_W-1:0] mode,
   output logic              legal,
   output logic [BANK_W-1:0] bank
);
   localparam int N = MBS_NUM_CODES;
   localparam logic [MODE_W-1:0] CODE_TBL [N] = '{
      MODE_W'(C_USER), MODE_W'(C_SYSUSR), MODE_W'(C_PRIV),
      MODE_W'(C_TRAP), MODE_W'(C_EXT),    MODE_W'(C_IRQ)};
   localparam int BANK_TBL [N] = '{0, 0, 1, 2, 3, 4};

   logic [N-1:0] hit;

   for (genvar i = 0; i < N; i++) begin : g_code
      if (BANK_TBL[i] >= NUM_BANKS) begin : g_bad_bank
         $error("mbs_mode_decode: bank table entry beyond NUM_BANKS");
      end
      for (genvar j = i + 1; j < N; j++) begin : g_dup
         if (CODE_TBL[i] == CODE_TBL[j]) begin : g_dup_err
            $error("mbs_mode_decode: two mode codes are equal");
         end
      end
      assign hit[i] = (mode == CODE_TBL[i]);
   end

   always_comb begin
      legal = |hit;
      bank  = '0;
      for (int i = 0; i < N; i++) begin
         if (hit[i]) bank = bank | BANK_W'(BANK_TBL[i]);
      end
   end
endmodule

// File: rtl/mbs_bank_store.sv
module mbs_bank_store #(
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 5,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_r29,
   input  logic [DATA_W-1:0] wr_r30,
   input  logic [DATA_W-1:0] wr_sts,
   input  logic [BANK_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_r29,
   output logic [DATA_W-1:0] rd_r30,
   output logic [DATA_W-1:0] rd_sts
);
   logic [DATA_W-1:0] b29 [NUM_BANKS];
   logic [DATA_W-1:0] b30 [NUM_BANKS];
   logic [DATA_W-1:0] bst [NUM_BANKS];
   logic [NUM_BANKS-1:0] we;
   logic [NUM_BANKS-1:0] sel;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
      assign we[g]  = wr_en && (wr_idx == BANK_W'(g));
      assign sel[g] = (rd_idx == BANK_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_BANKS; k++) begin
            b29[k] <= '0;
            b30[k] <= '0;
            bst[k] <= '0;
         end
      end else begin
         for (int k = 0; k < NUM_BANKS; k++) begin
            if (we[k]) begin
               b29[k] <= wr_r29;
               b30[k] <= wr_r30;
               bst[k] <= wr_sts;
            end
         end
      end
   end

   always_comb begin
      rd_r29 = '0;
      rd_r30 = '0;
      rd_sts = '0;
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (sel[k]) begin
            rd_r29 = b29[k];
            rd_r30 = b30[k];
            rd_sts = bst[k];
         end
      end
   end
endmodule

// File: rtl/mode_bank_swap.sv
module mode_bank_swap
   import mbs_pkg::*;
#(
   parameter int        DATA_W    = 32,
   parameter int        NUM_BANKS = MBS_NUM_BANKS,
   parameter mbs_mode_t C_USER    = MBS_USER,
   parameter mbs_mode_t C_SYSUSR  = MBS_SYSUSR,
   parameter mbs_mode_t C_PRIV    = MBS_PRIV,
   parameter mbs_mode_t C_TRAP    = MBS_TRAP,
   parameter mbs_mode_t C_EXT     = MBS_EXT,
   parameter mbs_mode_t C_IRQ     = MBS_IRQ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_req,
   input  logic [4:0]        req_mode,
   input  logic [DATA_W-1:0] live_r29,
   input  logic [DATA_W-1:0] live_r30,
   input  logic [DATA_W-1:0] live_sts,
   output logic [DATA_W-1:0] out_r29,
   output logic [DATA_W-1:0] out_r30,
   output logic [DATA_W-1:0] out_sts,
   output logic [4:0]        cur_mode,
   output logic              done,
   output logic              illegal_mode
);
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("mode_bank_swap: DATA_W must be positive");
   end
   if (NUM_BANKS < MBS_NUM_BANKS) begin : g_bad_banks
      $error("mode_bank_swap: NUM_BANKS too small for the mode table");
   end

   logic              req_legal;
   logic [BANK_W-1:0] req_bank;
   logic [BANK_W-1:0] cur_bank;
   logic              do_swap;
   logic              bad_req;
   logic [DATA_W-1:0] rd_r29, rd_r30, rd_sts;
   logic [DATA_W-1:0] nx_r29, nx_r30, nx_sts;

   mbs_mode_decode #(
      .MODE_W(MBS_MODE_W), .NUM_BANKS(NUM_BANKS),
      .C_USER(C_USER), .C_SYSUSR(C_SYSUSR), .C_PRIV(C_PRIV),
      .C_TRAP(C_TRAP), .C_EXT(C_EXT), .C_IRQ(C_IRQ)
   ) u_dec (
      .mode (req_mode),
      .legal(req_legal),
      .bank (req_bank)
   );

   assign do_swap = sw_req && req_legal && (req_mode != cur_mode);
   assign bad_req = sw_req && !req_legal;

   mbs_bank_store #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (do_swap),
      .wr_idx(cur_bank),
      .wr_r29(live_r29),
      .wr_r30(live_r30),
      .wr_sts(live_sts),
      .rd_idx(req_bank),
      .rd_r29(rd_r29),
      .rd_r30(rd_r30),
      .rd_sts(rd_sts)
   );

   // Save precedes load: a shared bank hands back what is being saved now.
   always_comb begin
      if (req_bank == cur_bank) begin
         nx_r29 = live_r29;
         nx_r30 = live_r30;
         nx_sts = live_sts;
      end else begin
         nx_r29 = rd_r29;
         nx_r30 = rd_r30;
         nx_sts = rd_sts;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_r29      <= '0;
         out_r30      <= '0;
         out_sts      <= '0;
         cur_mode     <= C_USER;
         cur_bank     <= '0;
         done         <= 1'b0;
         illegal_mode <= 1'b0;
      end else begin
         done         <= do_swap;
         illegal_mode <= bad_req;
         if (do_swap) begin
            out_r29  <= nx_r29;
            out_r30  <= nx_r30;
            out_sts  <= nx_sts;
            cur_mode <= req_mode;
            cur_bank <= req_bank;
         end
      end
   end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker
   import mbs_pkg::*;
#(
   parameter int        DATA_W   = 32,
   parameter mbs_mode_t C_USER   = MBS_USER,
   parameter mbs_mode_t C_SYSUSR = MBS_SYSUSR,
   parameter mbs_mode_t C_PRIV   = MBS_PRIV,
   parameter mbs_mode_t C_TRAP   = MBS_TRAP,
   parameter mbs_mode_t C_EXT    = MBS_EXT,
   parameter mbs_mode_t C_IRQ    = MBS_IRQ
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_req,
   input logic [4:0]        req_mode,
   input logic [DATA_W-1:0] live_r29,
   input logic [DATA_W-1:0] live_r30,
   input logic [DATA_W-1:0] live_sts,
   input logic [DATA_W-1:0] out_r29,
   input logic [DATA_W-1:0] out_r30,
   input logic [DATA_W-1:0] out_sts,
   input logic [4:0]        cur_mode,
   input logic              done,
   input logic              illegal_mode
);
   logic known;
   logic in_b0_req, in_b0_cur;
   assign known = (req_mode == C_USER) || (req_mode == C_SYSUSR) ||
                  (req_mode == C_PRIV) || (req_mode == C_TRAP) ||
                  (req_mode == C_EXT)  || (req_mode == C_IRQ);
   assign in_b0_req = (req_mode == C_USER) || (req_mode == C_SYSUSR);
   assign in_b0_cur = (cur_mode == C_USER) || (cur_mode == C_SYSUSR);

   AST_SWITCH_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && known && (req_mode != cur_mode) |=> cur_mode == $past(req_mode)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_req |=> $stable(cur_mode) && $stable(out_r29) && $stable(out_sts) && !done); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && known && (req_mode != cur_mode) |=> done && !illegal_mode); // R4
   AST_SAME_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && (req_mode == cur_mode) |=> !done && $stable(out_r30) && $stable(cur_mode)); // R5
   AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && !known |=> illegal_mode && !done && $stable(cur_mode) && $stable(out_r29)); // R6
   AST_ILLEGAL_ONLY_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_req && !known) |=> !illegal_mode); // R6
   AST_SHARED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req && known && (req_mode != cur_mode) && in_b0_req && in_b0_cur
      |=> out_r29 == $past(live_r29) && out_r30 == $past(live_r30) && out_sts == $past(live_sts)); // R7
endmodule

bind mode_bank_swap mbs_checker #(
   .DATA_W(DATA_W), .C_USER(C_USER), .C_SYSUSR(C_SYSUSR), .C_PRIV(C_PRIV),
   .C_TRAP(C_TRAP), .C_EXT(C_EXT), .C_IRQ(C_IRQ)
) u_mbs_chk (
   .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .req_mode(req_mode),
   .live_r29(live_r29), .live_r30(live_r30), .live_sts(live_sts),
   .out_r29(out_r29), .out_r30(out_r30), .out_sts(out_sts),
   .cur_mode(cur_mode), .done(done), .illegal_mode(illegal_mode)
);

// File: tb/tb_mode_bank_swap.sv
`timescale 1ns/1ps
module tb_mode_bank_swap;
   localparam logic [4:0] M_USER = 5'h10, M_SYSU = 5'h1F, M_PRIV = 5'h13,
                          M_TRAP = 5'h17, M_EXT = 5'h1B, M_IRQ = 5'h12;

   typedef struct packed {
      logic [31:0] r29;
      logic [31:0] r30;
      logic [31:0] sts;
      logic [4:0]  mode;
      logic        done;
      logic        ill;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_req = 1'b0;
   logic [4:0]  req_mode = '0;
   logic [31:0] live_r29 = '0, live_r30 = '0, live_sts = '0;
   logic [31:0] out_r29, out_r30, out_sts;
   logic [4:0]  cur_mode;
   logic        done, illegal_mode;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   exp_t  expq[$];
   string tagq[$];

   logic [31:0] m29 [5];
   logic [31:0] m30 [5];
   logic [31:0] mst [5];
   logic [31:0] o29, o30, ost;
   logic [4:0]  mcur;

   always #2 clk = ~clk;

   mode_bank_swap #(.DATA_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .req_mode(req_mode),
      .live_r29(live_r29), .live_r30(live_r30), .live_sts(live_sts),
      .out_r29(out_r29), .out_r30(out_r30), .out_sts(out_sts),
      .cur_mode(cur_mode), .done(done), .illegal_mode(illegal_mode)
   );

   function automatic bit known(input logic [4:0] m);
      return (m == M_USER) || (m == M_SYSU) || (m == M_PRIV) ||
             (m == M_TRAP) || (m == M_EXT)  || (m == M_IRQ);
   endfunction

   function automatic int bank_of(input logic [4:0] m);
      case (m)
         M_PRIV:  return 1;
         M_TRAP:  return 2;
         M_EXT:   return 3;
         M_IRQ:   return 4;
         default: return 0;
      endcase
   endfunction

   task automatic step(input logic s, input logic [4:0] m,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input string tag);
      exp_t e;
      @(negedge clk);
      sw_req = s; req_mode = m; live_r29 = a; live_r30 = b; live_sts = c;
      e.done = 1'b0;
      e.ill  = 1'b0;
      if (s) begin
         if (!known(m)) begin
            e.ill = 1'b1;
         end else if (m != mcur) begin
            m29[bank_of(mcur)] = a;
            m30[bank_of(mcur)] = b;
            mst[bank_of(mcur)] = c;
            o29 = m29[bank_of(m)];
            o30 = m30[bank_of(m)];
            ost = mst[bank_of(m)];
            mcur = m;
            e.done = 1'b1;
         end
      end
      e.r29 = o29; e.r30 = o30; e.sts = ost; e.mode = mcur;
      expq.push_back(e);
      tagq.push_back(tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (expq.size() > 0) begin
         exp_t  e;
         string t;
         e = expq.pop_front();
         t = tagq.pop_front();
         n_checks++;
         if (out_r29 !== e.r29 || out_r30 !== e.r30 || out_sts !== e.sts ||
             cur_mode !== e.mode || done !== e.done || illegal_mode !== e.ill) begin
            n_fail++;
            $display("FAIL %s: got r29=%h r30=%h sts=%h mode=%h done=%b ill=%b exp r29=%h r30=%h sts=%h mode=%h done=%b ill=%b",
                     t, out_r29, out_r30, out_sts, cur_mode, done, illegal_mode,
                     e.r29, e.r30, e.sts, e.mode, e.done, e.ill);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 5; k++) begin
         m29[k] = '0; m30[k] = '0; mst[k] = '0;
      end
      o29 = '0; o30 = '0; ost = '0; mcur = M_USER;
      repeat (3) @(negedge clk);
      // R1: reset state while reset is held
      n_checks++;
      if (out_r29 !== 0 || out_r30 !== 0 || out_sts !== 0 || cur_mode !== M_USER ||
          done !== 0 || illegal_mode !== 0) begin
         n_fail++;
         $display("FAIL R1: got r29=%h mode=%h done=%b ill=%b expected 0 10 0 0",
                  out_r29, cur_mode, done, illegal_mode);
      end
      rst_n = 1'b1;
      step(0, M_USER, 32'h1111, 32'h2222, 32'h3333, "R1 after reset");
      step(1, M_PRIV, 32'hA29, 32'hA30, 32'hA5, "R3 user->priv");
      step(1, M_TRAP, 32'hB29, 32'hB30, 32'hB5, "R4 priv->trap");
      step(1, M_PRIV, 32'hC29, 32'hC30, 32'hC5, "R3 trap->priv restores priv bank");
      step(0, M_TRAP, 32'hDEAD, 32'hBEEF, 32'hF00D, "R3 idle hold");
      step(1, M_PRIV, 32'hD29, 32'hD30, 32'hD5, "R5 same mode");
      step(1, 5'h00, 32'hE29, 32'hE30, 32'hE5, "R6 unknown code 00");
      step(1, 5'h1E, 32'hE291, 32'hE301, 32'hE51, "R6 unknown code 1E");
      step(1, M_USER, 32'hF29, 32'hF30, 32'hF5, "R2 priv->user bank0");
      step(1, M_SYSU, 32'h6029, 32'h6030, 32'h605, "R7 user->sysuser shared bank");
      step(1, M_EXT, 32'h7029, 32'h7030, 32'h705, "R2 sysuser->ext");
      step(1, M_IRQ, 32'h8029, 32'h8030, 32'h805, "R2 ext->irq");
      step(1, M_EXT, 32'h9029, 32'h9030, 32'h905, "R8 irq->ext");
      step(1, M_TRAP, 32'hAA29, 32'hAA30, 32'hAA5, "R8 ext->trap keeps trap bank");
      step(1, M_USER, 32'hBB29, 32'hBB30, 32'hBB5, "R4 back-to-back first");
      step(1, M_PRIV, 32'hCC29, 32'hCC30, 32'hCC5, "R4 back-to-back second");
      step(1, 5'h0F, 32'h1, 32'h2, 32'h3, "R6 unknown after switch");
      step(1, M_SYSU, 32'hDD29, 32'hDD30, 32'hDD5, "R2 priv->sysuser bank0");
      step(1, M_USER, 32'hEE29, 32'hEE30, 32'hEE5, "R7 sysuser->user shared bank");
      step(0, M_USER, 32'h0, 32'h0, 32'h0, "R4 done falls when idle");
      step(0, M_USER, 32'h0, 32'h0, 32'h0, "R3 idle hold");
      @(negedge clk);
      sw_req = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule